// File: doc/BRIEF.md
# Cache Line Coherence State and Write-Policy Controller

This block looks at one processor access at a time: a load or a store, together with the tag lookup result and the line's current coherence state. It decides whether the access needs an external bus cycle and of what kind, and it gives the line's next coherence state. The four states are modified, exclusive, shared and invalid. A store that misses is not allocated. It is handed to a two-entry posted store queue, and the block keeps that queue's fill level. The bus side reports each entry that leaves the queue with a one-cycle drain pulse.

The write policy is chosen per line. A bus-side policy pin is sampled with each bus cycle; a high value means write-back and a low value means write-through. A page-level write-through bit overrides the pin. With the pin driven from the processor's write-in-progress indication, the result is write-once: the first write to a shared line is written through and promotes the line to exclusive, so later writes stay in the cache. A locked access always produces a bus cycle. Snoop transitions, the data path and bus timing belong to neighbouring blocks.

Top module: `mesi_wp_ctrl`

## Requirements
- R1: An unlocked write hit to a line in state E (code 2) or M (code 3) on a page whose write-through bit is clear issues no bus cycle (bus code 0) and leaves the line in M.
- R2: A write hit to a line in state S (code 1) issues a single bus write (bus code 2). The line moves to E if the policy pin is 1 and the page write-through bit is 0; otherwise it stays in S.
- R3: When the page write-through bit is set, every write hit issues a bus write, the policy pin has no effect on the next state, E and M lines keep their state, and a read-miss fill enters S.
- R4: A read miss to a cacheable address requests a line fill (bus code 1). The line enters E when the policy pin is 1 and the page write-through bit is 0, and enters S otherwise.
- R5: A read miss to an uncacheable address requests a single bus read (bus code 3) and leaves the line invalid (state code 0).
- R6: An unlocked read hit issues no bus cycle and keeps the line's state. A lookup hit reported on a line in state I counts as a miss.
- R7: A locked access always issues a bus cycle. A locked read hit issues a single read (code 3). A locked write hit issues a bus write and keeps E or M unchanged. A locked write miss issues a bus write directly, bypassing the store queue, and leaves the line invalid.
- R8: An unlocked write miss pushes the store into the posted queue (push strobe high), issues no direct bus cycle, gives next state I, and raises the queue level by one on the next clock edge.
- R9: While the queue holds 2 entries, an unlocked write miss is stalled. Ready is low, nothing is pushed, no bus cycle is issued, the next state equals the current state, and the level is unchanged unless a drain occurs.
- R10: A drain pulse lowers the level by one. A drain at level 0 is ignored. A push and a drain in the same cycle leave the level unchanged.
- R11: With no valid access, ready is high, no bus cycle is issued, nothing is pushed, and the next state equals the current state.
- R12: After reset the queue level is 0 and ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_hit | input | 1 | Tag lookup hit |
| cur_state | input | 2 | Current line state: 0 I, 1 S, 2 E, 3 M |
| page_wt | input | 1 | Page-level write-through bit |
| cacheable | input | 1 | Address may be cached |
| locked | input | 1 | Access belongs to a locked sequence |
| policy_pin | input | 1 | Bus-side policy: 1 write-back, 0 write-through |
| sb_drain | input | 1 | One queued store left for the bus |
| acc_ready | output | 1 | Access accepted this cycle |
| bus_req | output | 2 | 0 none, 1 line fill, 2 single write, 3 single read |
| next_state | output | 2 | Line state after the access |
| sb_push | output | 1 | Store written into the posted queue |
| sb_level | output | 2 | Entries held in the posted queue |

## Verification
Directed cases walk every combination of access type, hit, and current state, with the policy pin at 0 and at 1 and the page bit at 0 and at 1. This separates the write-once promotion from S from the cases where the page bit forces write-through. Locked variants of the same accesses show that a bus cycle appears where an unlocked hit would be silent. Back-to-back store misses with the drain held low fill the queue and expose the stall. Drain pulses at level 0, and drains coinciding with pushes, check the level arithmetic. Random mixes of all inputs, compared against a bench reference function, then cover state/policy combinations the directed list does not name.

// File: rtl/mesi_wp_pkg.sv
package mesi_wp_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    BUS_NONE  = 2'd0,
    BUS_FILL  = 2'd1,
    BUS_WRITE = 2'd2,
    BUS_READ  = 2'd3
  } bus_op_t;

  // State a freshly filled line takes: exclusive only when write-back is allowed.
  function automatic line_st_t fill_state(input logic pin, input logic page_wt);
    return (pin && !page_wt) ? ST_E : ST_S;
  endfunction

  // State after a written-through store hit.
  function automatic line_st_t through_state(input line_st_t cur, input logic pin,
                                             input logic page_wt);
    if (cur == ST_S) return fill_state(pin, page_wt);
    return cur;
  endfunction

endpackage

// File: rtl/mesi_wp_decide.sv
module mesi_wp_decide
  import mesi_wp_pkg::*;
(
  input  logic       valid,
  input  logic       is_write,
  input  logic       hit_raw,
  input  line_st_t   cur,
  input  logic       page_wt,
  input  logic       cacheable,
  input  logic       locked,
  input  logic       pin,
  input  logic       queue_full,
  output logic       ready,
  output bus_op_t    bus,
  output line_st_t   nxt,
  output logic       push,
  output logic       stall_ev,
  output logic       through_ev
);
  logic hit;
  logic through;
  assign hit     = hit_raw && (cur != ST_I);
  assign through = (cur == ST_S) || page_wt || locked;

  always_comb begin
    ready      = 1'b1;
    bus        = BUS_NONE;
    nxt        = cur;
    push       = 1'b0;
    stall_ev   = 1'b0;
    through_ev = 1'b0;
    if (valid) begin
      if (!is_write) begin
        if (hit) begin
          bus = locked ? BUS_READ : BUS_NONE;
        end else if (cacheable) begin
          bus = BUS_FILL;
          nxt = fill_state(pin, page_wt);
        end else begin
          bus = BUS_READ;
          nxt = ST_I;
        end
      end else if (hit) begin
        if (through) begin
          bus        = BUS_WRITE;
          nxt        = through_state(cur, pin, page_wt);
          through_ev = 1'b1;
        end else begin
          nxt = ST_M;
        end
      end else if (locked) begin
        bus = BUS_WRITE;
        nxt = ST_I;
      end else if (queue_full) begin
        ready    = 1'b0;
        stall_ev = 1'b1;
      end else begin
        push = 1'b1;
        nxt  = ST_I;
      end
    end
  end
endmodule

// File: rtl/mesi_wp_sbuf_cnt.sv
module mesi_wp_sbuf_cnt #(
  parameter int DEPTH = 2,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          drain,
  output logic [LW-1:0] level,
  output logic          full
);
  logic pop;
  assign pop  = drain && (level != '0);
  assign full = (level == LW'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level <= '0;
    else if (push && !pop) level <= level + 1'b1;
    else if (pop && !push) level <= level - 1'b1;
  end
endmodule

// File: rtl/mesi_wp_ctrl.sv
module mesi_wp_ctrl
  import mesi_wp_pkg::*;
#(
  parameter int SB_DEPTH = 2,
  localparam int LW = $clog2(SB_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic          acc_hit,
  input  logic [1:0]    cur_state,
  input  logic          page_wt,
  input  logic          cacheable,
  input  logic          locked,
  input  logic          policy_pin,
  input  logic          sb_drain,
  output logic          acc_ready,
  output logic [1:0]    bus_req,
  output logic [1:0]    next_state,
  output logic          sb_push,
  output logic [LW-1:0] sb_level
);
  // Named internal events, observed by the bound checker.
  logic     queue_full;
  logic     stall_ev;
  logic     through_ev;
  bus_op_t  bus_op;
  line_st_t nxt_st;

  mesi_wp_decide u_decide (
    .valid      (acc_valid),
    .is_write   (acc_write),
    .hit_raw    (acc_hit),
    .cur        (line_st_t'(cur_state)),
    .page_wt    (page_wt),
    .cacheable  (cacheable),
    .locked     (locked),
    .pin        (policy_pin),
    .queue_full (queue_full),
    .ready      (acc_ready),
    .bus        (bus_op),
    .nxt        (nxt_st),
    .push       (sb_push),
    .stall_ev   (stall_ev),
    .through_ev (through_ev)
  );

  mesi_wp_sbuf_cnt #(.DEPTH(SB_DEPTH)) u_sbuf (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (sb_push),
    .drain (sb_drain),
    .level (sb_level),
    .full  (queue_full)
  );

  assign bus_req    = bus_op;
  assign next_state = nxt_st;
endmodule

// File: rtl/mesi_wp_chk.sv
module mesi_wp_chk #(
  parameter int SB_DEPTH = 2,
  localparam int LW = $clog2(SB_DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic          acc_write,
  input logic          acc_hit,
  input logic [1:0]    cur_state,
  input logic          page_wt,
  input logic          locked,
  input logic          sb_drain,
  input logic          acc_ready,
  input logic [1:0]    bus_req,
  input logic [1:0]    next_state,
  input logic          sb_push,
  input logic [LW-1:0] sb_level,
  input logic          stall_ev,
  input logic          through_ev
);
  a_r1_e_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_hit && cur_state == 2'd2 && !locked && !page_wt)
      |-> (bus_req == 2'd0 && next_state == 2'd3));

  a_r3_wt_goes_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_hit && cur_state != 2'd0 && page_wt)
      |-> (bus_req == 2'd2 && through_ev));

  a_r7_locked_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && locked) |-> (bus_req != 2'd0 && !sb_push));

  a_r8_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_push && !sb_drain) |=> (sb_level == $past(sb_level) + 1'b1));

  a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    stall_ev |-> (!acc_ready && !sb_push && bus_req == 2'd0 && sb_level == LW'(SB_DEPTH)));

  a_r10_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sb_level <= LW'(SB_DEPTH));

  a_r10_empty_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_level == '0 && !sb_push) |=> (sb_level == '0));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (acc_ready && bus_req == 2'd0 && !sb_push && next_state == cur_state));
endmodule

bind mesi_wp_ctrl mesi_wp_chk #(.SB_DEPTH(SB_DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .acc_write  (acc_write),
  .acc_hit    (acc_hit),
  .cur_state  (cur_state),
  .page_wt    (page_wt),
  .locked     (locked),
  .sb_drain   (sb_drain),
  .acc_ready  (acc_ready),
  .bus_req    (bus_req),
  .next_state (next_state),
  .sb_push    (sb_push),
  .sb_level   (sb_level),
  .stall_ev   (stall_ev),
  .through_ev (through_ev)
);

// File: tb/mesi_wp_ctrl_tb.sv
`timescale 1ns/1ps
module mesi_wp_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic v, w, h, wt, cach, lk, pin, drn;
  logic [1:0] cur;
  logic rdy, push;
  logic [1:0] bus, nxt, lvl;

  int checks = 0;
  int errors = 0;
  int mlvl = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mesi_wp_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(v), .acc_write(w), .acc_hit(h),
    .cur_state(cur), .page_wt(wt), .cacheable(cach), .locked(lk),
    .policy_pin(pin), .sb_drain(drn), .acc_ready(rdy), .bus_req(bus),
    .next_state(nxt), .sb_push(push), .sb_level(lvl)
  );

  // Expected {ready, push, bus[1:0], next[1:0]} from the requirements.
  function automatic logic [5:0] expect_out(input logic vv, ww, hh, input logic [1:0] cs,
                                            input logic pw, cc, ll, pp, input int level);
    logic rr, ps; logic [1:0] b, n;
    logic real_hit;
    logic [1:0] fill;
    rr = 1; ps = 0; b = 0; n = cs;
    real_hit = hh && (cs != 0);
    fill = (pp && !pw) ? 2'd2 : 2'd1;
    if (vv) begin
      if (!ww) begin
        if (real_hit) b = ll ? 2'd3 : 2'd0;          // R6 R7
        else if (cc) begin b = 2'd1; n = fill; end    // R4 R3
        else begin b = 2'd3; n = 2'd0; end            // R5
      end else if (real_hit) begin
        if (cs == 2'd1) begin b = 2'd2; n = fill; end // R2
        else if (pw || ll) b = 2'd2;                  // R3 R7
        else n = 2'd3;                                // R1
      end else if (ll) begin b = 2'd2; n = 2'd0; end  // R7
      else if (level >= 2) rr = 0;                    // R9
      else begin ps = 1; n = 2'd0; end                // R8
    end
    return {rr, ps, b, n};
  endfunction

  task automatic step(input string tag, input logic vv, ww, hh, input logic [1:0] cs,
                      input logic pw, cc, ll, pp, dd);
    logic [5:0] exp;
    @(negedge clk);
    v = vv; w = ww; h = hh; cur = cs; wt = pw; cach = cc; lk = ll; pin = pp; drn = dd;
    #1;
    exp = expect_out(vv, ww, hh, cs, pw, cc, ll, pp, mlvl);
    checks++;
    if ({rdy, push, bus, nxt} !== exp || int'(lvl) != mlvl) begin
      errors++;
      $display("FAIL %s: got rdy=%b push=%b bus=%0d nxt=%0d lvl=%0d exp rdy=%b push=%b bus=%0d nxt=%0d lvl=%0d",
               tag, rdy, push, bus, nxt, lvl, exp[5], exp[4], exp[3:2], exp[1:0], mlvl);
    end
    if (exp[4] && !(dd && mlvl > 0)) mlvl++;
    else if (!exp[4] && dd && mlvl > 0) mlvl--;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    v = 0; w = 0; h = 0; cur = 0; wt = 0; cach = 0; lk = 0; pin = 0; drn = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R12 reset state
    step("R12", 0, 0, 0, 2'd0, 0, 0, 0, 0, 0);
    // R11 idle with odd inputs
    step("R11", 0, 1, 1, 2'd2, 1, 1, 1, 1, 0);
    // R1
    step("R1", 1, 1, 1, 2'd2, 0, 1, 0, 0, 0);
    step("R1", 1, 1, 1, 2'd3, 0, 1, 0, 1, 0);
    // R2 write-once promotion and no promotion
    step("R2", 1, 1, 1, 2'd1, 0, 1, 0, 1, 0);
    step("R2", 1, 1, 1, 2'd1, 0, 1, 0, 0, 0);
    // R3 page write-through
    step("R3", 1, 1, 1, 2'd1, 1, 1, 0, 1, 0);
    step("R3", 1, 1, 1, 2'd2, 1, 1, 0, 1, 0);
    step("R3", 1, 0, 0, 2'd0, 1, 1, 0, 1, 0);
    // R4 fills
    step("R4", 1, 0, 0, 2'd0, 0, 1, 0, 1, 0);
    step("R4", 1, 0, 0, 2'd0, 0, 1, 0, 0, 0);
    // R5
    step("R5", 1, 0, 0, 2'd0, 0, 0, 0, 1, 0);
    // R6 including hit on invalid line
    step("R6", 1, 0, 1, 2'd3, 0, 1, 0, 0, 0);
    step("R6", 1, 0, 1, 2'd0, 0, 1, 0, 1, 0);
    // R7 locked
    step("R7", 1, 0, 1, 2'd2, 0, 1, 1, 0, 0);
    step("R7", 1, 1, 1, 2'd3, 0, 1, 1, 0, 0);
    step("R7", 1, 1, 0, 2'd0, 0, 1, 1, 0, 0);
    // R10 drain at empty
    step("R10", 0, 0, 0, 2'd0, 0, 0, 0, 0, 1);
    // R8 fill queue, R9 stall
    step("R8", 1, 1, 0, 2'd0, 0, 1, 0, 0, 0);
    step("R8", 1, 1, 0, 2'd0, 0, 1, 0, 0, 0);
    step("R9", 1, 1, 0, 2'd2, 0, 1, 0, 0, 0);
    step("R9", 1, 1, 0, 2'd1, 0, 1, 0, 1, 0);
    // R10 drain then push with drain
    step("R10", 0, 0, 0, 2'd0, 0, 0, 0, 0, 1);
    step("R10", 1, 1, 0, 2'd0, 0, 1, 0, 0, 1);
    step("R10", 0, 0, 0, 2'd0, 0, 0, 0, 0, 0);
    // R1..R11 random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom();
      step("R1-mix", r[0] | r[1], r[2], r[3], r[5:4], r[6] & r[7], r[8] | r[9],
           r[10] & r[11] & r[12], r[13], r[14] & r[15]);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule